// File: doc/BRIEF.md
# Serial Flash Continuous-Read Responder

This block is the device side of an SPI link for a page-organised serial flash, cut down to its sequential read path. A host selects the device and shifts in a read opcode and a three-byte address. For the faster read opcodes it then shifts in one or two throwaway bytes. From that point the block streams memory bytes, most significant bit first, for as long as the host keeps clocking. The read pointer runs past the end of a page into the next page, and past the end of the last page back to page zero, with no idle bits. Releasing chip select ends the read at once and floats the output.

The array is a small synthesizable pattern store of `PAGES` pages. Each page holds 528 bytes in the extended page layout and 512 in the binary layout. The pins are oversampled on a fast system clock. Output bits are launched after each falling serial-clock edge and input bits are taken at each rising edge, so serial modes 0 and 3 both work.

The control FSM has the states IDLE, OPCODE, ADDRESS, DUMMY, STREAM and REJECT, with these transitions:
- *select*: IDLE to OPCODE when chip select goes low.
- *decode-ok*: OPCODE to ADDRESS on a known opcode.
- *decode-bad*: OPCODE to REJECT on any other opcode.
- *addr-done*: ADDRESS to DUMMY, or straight to STREAM when no dummy bytes are required.
- *dummy-done*: DUMMY to STREAM.
- *release*: any state to IDLE when chip select goes high.

Top module: `flash_rd_resp`

## Requirements
- R1: After reset, and whenever chip select is high, `spi_miso_oe` is low.
- R2: Opcode 0x03 is followed by three address bytes, MSB first, and no dummy bytes. The first data bit is driven after the falling clock edge that follows the last address bit. `spi_miso_oe` stays low during the whole command phase. The byte at page p, offset b is (29*p + 3*b + floor(b/256)) mod 256.
- R3: Opcode 0x0B requires exactly one dummy byte after the address, and the value of that byte has no effect on the data.
- R4: Opcode 0x1B requires exactly two dummy bytes after the address, and their values have no effect on the data.
- R5: With `bin_pages`=0 (528-byte pages), address bits [9:0] give the start offset and the next log2(PAGES) bits give the page. Higher address bits are ignored. The byte after offset 527 is offset 0 of the next page, with no gap.
- R6: With `bin_pages`=1 (512-byte pages), address bits [8:0] give the offset and the next log2(PAGES) bits give the page. Higher address bits are ignored. The byte after offset 511 is offset 0 of the next page.
- R7: In both layouts, the byte after the last byte of page PAGES-1 is byte 0 of page 0, with no gap.
- R8: A rise of chip select, even in the middle of a byte, drops `spi_miso_oe` within three system clocks. The next selection starts again with a fresh opcode.
- R9: After an unknown opcode, `spi_miso_oe` stays low for the rest of that selection, whatever is clocked in.
- R10: `spi_miso` changes only in response to a falling serial-clock edge and holds its value across the rising edge that samples it.
- R11: Reads behave the same whether the serial clock idles low (mode 0) or high (mode 3) when chip select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| bin_pages | input | 1 | Page layout: 1 = 512-byte pages, 0 = 528-byte pages; held stable while selected |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; low means high impedance |

## Verification
The page crossover and the array wraparound can occur on the same pointer step, when a stream reaches the final byte of the last page. Directed reads start a few bytes before that point in both page layouts, and the random reads are biased to start within four bytes of a page end. Every streamed byte is compared with a closed-form linear-address model, so a missed carry or a late wrap shows up as a wrong byte. A chip-select release can also land in the same window as a falling-edge output update; a directed case stops mid-byte and checks the enable and a clean restart.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_OPCODE = 3'd1,
        ST_ADDR   = 3'd2,
        ST_DUMMY  = 3'd3,
        ST_STREAM = 3'd4,
        ST_REJECT = 3'd5
    } rd_state_e;

    localparam logic [7:0] OPC_READ_SLOW = 8'h03;
    localparam logic [7:0] OPC_READ_FAST = 8'h0B;
    localparam logic [7:0] OPC_READ_HIGH = 8'h1B;

    localparam int ADDR_BYTES = 3;

    // opcode recognised by the read path
    function automatic logic opcode_known(input logic [7:0] opc);
        return (opc == OPC_READ_SLOW) || (opc == OPC_READ_FAST) || (opc == OPC_READ_HIGH);
    endfunction

    // number of throwaway bytes between address and data
    function automatic logic [1:0] dummy_count(input logic [7:0] opc);
        logic [1:0] n;
        n = 2'd0;
        if (opc == OPC_READ_FAST) n = 2'd1;
        if (opc == OPC_READ_HIGH) n = 2'd2;
        return n;
    endfunction

    // content of the pattern store at a page and byte offset
    function automatic logic [7:0] pattern_byte(input int unsigned pg, input int unsigned off);
        int unsigned v;
        v = pg * 29 + off * 3 + (off >> 8);
        return 8'(v);
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic rise_o,
    output logic fall_o,
    output logic cs_hi_o,
    output logic mosi_o
);
    localparam int MSB = STAGES - 1;

    logic [MSB:0] sck_r;
    logic [MSB:0] cs_r;
    logic [MSB:0] mosi_r;
    logic         sck_last;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_r  <= '0;
                    cs_r   <= '1;
                    mosi_r <= '0;
                end else begin
                    sck_r  <= sck_i;
                    cs_r   <= cs_n_i;
                    mosi_r <= mosi_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_r  <= '0;
                    cs_r   <= '1;
                    mosi_r <= '0;
                end else begin
                    sck_r  <= {sck_r[MSB-1:0], sck_i};
                    cs_r   <= {cs_r[MSB-1:0], cs_n_i};
                    mosi_r <= {mosi_r[MSB-1:0], mosi_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_last <= 1'b0;
        else        sck_last <= sck_r[MSB];
    end

    assign rise_o  = sck_r[MSB] & ~sck_last;
    assign fall_o  = ~sck_r[MSB] & sck_last;
    assign cs_hi_o = cs_r[MSB];
    assign mosi_o  = mosi_r[MSB];

endmodule

// File: rtl/pattern_rom.sv
module pattern_rom
    import flash_rd_pkg::*;
#(
    parameter int PG_W  = 2,
    parameter int OFF_W = 10
) (
    input  logic [PG_W-1:0]  page_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [7:0]       data_o
);
    always_comb begin
        data_o = pattern_byte(32'(page_i), 32'(off_i));
    end
endmodule

// File: rtl/read_cursor.sv
module read_cursor #(
    parameter int PAGES     = 4,
    parameter int EXT_BYTES = 528,
    parameter int BIN_BYTES = 512,
    parameter int ADDR_W    = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic                       bin_i,
    input  logic                       adv_i,
    output logic [$clog2(PAGES)-1:0]   page_o,
    output logic [$clog2(EXT_BYTES)-1:0] off_o
);
    localparam int PG_W      = $clog2(PAGES);
    localparam int OFF_W     = $clog2(EXT_BYTES);
    localparam int BIN_OFF_W = $clog2(BIN_BYTES);
    localparam logic [PG_W-1:0]  LAST_PG  = PG_W'(PAGES - 1);
    localparam logic [OFF_W-1:0] EXT_LAST = OFF_W'(EXT_BYTES - 1);
    localparam logic [OFF_W-1:0] BIN_LAST = OFF_W'(BIN_BYTES - 1);

    logic [PG_W-1:0]  ld_page;
    logic [OFF_W-1:0] ld_off;
    logic [OFF_W-1:0] last_off;

    always_comb begin
        if (bin_i) begin
            ld_page = addr_i[BIN_OFF_W +: PG_W];
            ld_off  = OFF_W'(addr_i[BIN_OFF_W-1:0]);
        end else begin
            ld_page = addr_i[OFF_W +: PG_W];
            ld_off  = addr_i[OFF_W-1:0];
        end
        last_off = bin_i ? BIN_LAST : EXT_LAST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_o <= '0;
            off_o  <= '0;
        end else if (load_i) begin
            page_o <= ld_page;
            off_o  <= ld_off;
        end else if (adv_i) begin
            if (off_o >= last_off) begin
                off_o  <= '0;
                page_o <= (page_o == LAST_PG) ? '0 : page_o + PG_W'(1);
            end else begin
                off_o <= off_o + OFF_W'(1);
            end
        end
    end
endmodule

// File: rtl/flash_rd_resp.sv
module flash_rd_resp
    import flash_rd_pkg::*;
#(
    parameter int PAGES       = 4,
    parameter int EXT_BYTES   = 528,
    parameter int BIN_BYTES   = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bin_pages,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);
    localparam int PG_W   = $clog2(PAGES);
    localparam int OFF_W  = $clog2(EXT_BYTES);
    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam logic [1:0] LAST_ADDR_BYTE = 2'(ADDR_BYTES - 1);

    logic rise_evt, fall_evt, cs_hi, mosi_s;

    rd_state_e state_q, state_d;

    logic [2:0]        bit_cnt_q;
    logic [1:0]        byte_cnt_q;
    logic [6:0]        in_sh_q;
    logic [ADDR_W-2:0] addr_q;
    logic [1:0]        dummy_q;
    logic              mode_q;

    logic [2:0]        out_cnt_q;
    logic [7:0]        out_sh_q;

    logic              byte_done;
    logic [7:0]        rx_byte;
    logic [ADDR_W-1:0] full_addr;
    logic              ptr_load;
    logic              ptr_adv;
    logic [PG_W-1:0]   ptr_page;
    logic [OFF_W-1:0]  ptr_off;
    logic [7:0]        rom_byte;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_i   (spi_sck),
        .cs_n_i  (spi_cs_n),
        .mosi_i  (spi_mosi),
        .rise_o  (rise_evt),
        .fall_o  (fall_evt),
        .cs_hi_o (cs_hi),
        .mosi_o  (mosi_s)
    );

    read_cursor #(
        .PAGES(PAGES), .EXT_BYTES(EXT_BYTES), .BIN_BYTES(BIN_BYTES), .ADDR_W(ADDR_W)
    ) u_cursor (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ptr_load),
        .addr_i (full_addr),
        .bin_i  (mode_q),
        .adv_i  (ptr_adv),
        .page_o (ptr_page),
        .off_o  (ptr_off)
    );

    pattern_rom #(.PG_W(PG_W), .OFF_W(OFF_W)) u_rom (
        .page_i (ptr_page),
        .off_i  (ptr_off),
        .data_o (rom_byte)
    );

    assign byte_done = rise_evt && (bit_cnt_q == 3'd7);
    assign rx_byte   = {in_sh_q, mosi_s};
    assign full_addr = {addr_q, mosi_s};
    assign ptr_load  = (state_q == ST_ADDR) && byte_done && (byte_cnt_q == LAST_ADDR_BYTE);
    assign ptr_adv   = fall_evt && (state_q == ST_STREAM) && (out_cnt_q == 3'd0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_hi) begin
            state_d = ST_IDLE;                                    // release
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_OPCODE;                   // select
                ST_OPCODE: if (byte_done)
                               state_d = opcode_known(rx_byte) ? ST_ADDR : ST_REJECT;
                ST_ADDR:   if (ptr_load)
                               state_d = (dummy_q == 2'd0) ? ST_STREAM : ST_DUMMY;
                ST_DUMMY:  if (byte_done && (byte_cnt_q == dummy_q - 2'd1))
                               state_d = ST_STREAM;
                ST_STREAM: state_d = ST_STREAM;
                ST_REJECT: state_d = ST_REJECT;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // command capture on rising serial-clock edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            byte_cnt_q <= '0;
            in_sh_q    <= '0;
            addr_q     <= '0;
            dummy_q    <= '0;
            mode_q     <= 1'b0;
        end else if (cs_hi) begin
            bit_cnt_q  <= '0;
            byte_cnt_q <= '0;
        end else if (rise_evt && (state_q inside {ST_OPCODE, ST_ADDR, ST_DUMMY})) begin
            in_sh_q   <= rx_byte[6:0];
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (state_q == ST_ADDR) addr_q <= full_addr[ADDR_W-2:0];
            if (bit_cnt_q == 3'd7) begin
                if (state_q == ST_OPCODE) begin
                    dummy_q <= dummy_count(rx_byte);
                    mode_q  <= bin_pages;
                end
                byte_cnt_q <= ((state_q == ST_OPCODE) || ptr_load) ? 2'd0 : byte_cnt_q + 2'd1;
            end
        end
    end

    // output launch on falling serial-clock edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spi_miso  <= 1'b0;
            out_sh_q  <= '0;
            out_cnt_q <= '0;
        end else if (cs_hi) begin
            out_cnt_q <= '0;
        end else if (fall_evt && (state_q == ST_STREAM)) begin
            if (out_cnt_q == 3'd0) begin
                spi_miso  <= rom_byte[7];
                out_sh_q  <= {rom_byte[6:0], 1'b0};
                out_cnt_q <= 3'd7;
            end else begin
                spi_miso  <= out_sh_q[7];
                out_sh_q  <= {out_sh_q[6:0], 1'b0};
                out_cnt_q <= out_cnt_q - 3'd1;
            end
        end
    end

    always_comb begin
        spi_miso_oe = (state_q == ST_STREAM);
    end

endmodule

// File: rtl/flash_rd_resp_chk.sv
module flash_rd_resp_chk
    import flash_rd_pkg::*;
#(
    parameter int PAGES     = 4,
    parameter int EXT_BYTES = 528,
    parameter int BIN_BYTES = 512
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         spi_cs_n,
    input logic                         spi_miso,
    input logic                         spi_miso_oe,
    input rd_state_e                    st,
    input logic                         rise_evt,
    input logic                         fall_evt,
    input logic                         adv,
    input logic [$clog2(PAGES)-1:0]     pg,
    input logic [$clog2(EXT_BYTES)-1:0] off,
    input logic                         bin_mode
);
    localparam int PG_W  = $clog2(PAGES);
    localparam int OFF_W = $clog2(EXT_BYTES);
    localparam logic [PG_W-1:0]  LAST_PG  = PG_W'(PAGES - 1);
    localparam logic [OFF_W-1:0] EXT_LAST = OFF_W'(EXT_BYTES - 1);
    localparam logic [OFF_W-1:0] BIN_LAST = OFF_W'(BIN_BYTES - 1);

    logic [OFF_W-1:0] lim;
    assign lim = bin_mode ? BIN_LAST : EXT_LAST;

    // R8
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso_oe);

    // R10
    miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_miso) |-> $past(fall_evt));

    // R2
    stream_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_miso_oe) |-> $past(rise_evt));

    // R9
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REJECT) |=> (st == ST_REJECT || st == ST_IDLE));

    // R5
    offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (off <= lim));

    // R6
    page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && off == lim && pg != LAST_PG) |=> (off == '0 && pg == $past(pg) + PG_W'(1)));

    // R7
    array_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && off == lim && pg == LAST_PG) |=> (off == '0 && pg == '0));

endmodule

bind flash_rd_resp flash_rd_resp_chk #(
    .PAGES(PAGES), .EXT_BYTES(EXT_BYTES), .BIN_BYTES(BIN_BYTES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .st          (state_q),
    .rise_evt    (rise_evt),
    .fall_evt    (fall_evt),
    .adv         (ptr_adv),
    .pg          (ptr_page),
    .off         (ptr_off),
    .bin_mode    (mode_q)
);

// File: tb/sim_flash_rd_resp.sv
module sim_flash_rd_resp;
    localparam int PAGES = 4;
    localparam int EXT   = 528;
    localparam int BIN   = 512;
    localparam int H     = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bin_pages = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso, oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flash_rd_resp #(.PAGES(PAGES), .EXT_BYTES(EXT), .BIN_BYTES(BIN)) u0 (
        .clk(clk), .rst_n(rst_n), .bin_pages(bin_pages),
        .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] content(input int p, input int b);
        int v;
        v = p * 29 + b * 3 + b / 256;
        return 8'(v);
    endfunction

    function automatic logic [7:0] exp_byte(input bit binm, input logic [23:0] a, input int idx);
        int psz, p, o, lin;
        psz = binm ? BIN : EXT;
        p   = binm ? (int'(a) >> 9) % PAGES : (int'(a) >> 10) % PAGES;
        o   = binm ? int'(a) % 512 : int'(a) % 1024;
        lin = (p * psz + o + idx) % (PAGES * psz);
        return content(lin / psz, lin % psz);
    endfunction

    // one byte each way; a falling edge opens every bit
    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                        output bit oe_all, output bit oe_any, output bit held);
        oe_all = 1'b1; oe_any = 1'b0; held = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; mosi = tx[i];
            repeat (H) @(negedge clk);
            rx[i] = miso;
            oe_all &= oe; oe_any |= oe;
            sck = 1'b1;
            repeat (H) @(negedge clk);
            if (miso !== rx[i]) held = 1'b0;
        end
    endtask

    task automatic begin_sel(input bit idle_hi);
        sck = idle_hi;
        repeat (H) @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic end_sel(input bit idle_hi);
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check(oe == 1'b0, "R8 release", oe, 0);
        sck = idle_hi;
        repeat (H) @(negedge clk);
    endtask

    task automatic do_read(input logic [7:0] opc, input logic [23:0] a, input bit binm,
                           input int len, input bit idle_hi, input string req);
        logic [7:0] rx;
        bit all, any, held, quiet;
        int nd;
        bin_pages = binm;
        begin_sel(idle_hi);
        quiet = 1'b1;
        xfer(opc, rx, all, any, held); quiet &= !any;
        for (int k = 2; k >= 0; k--) begin
            xfer(a[8*k +: 8], rx, all, any, held); quiet &= !any;
        end
        nd = (opc == 8'h1B) ? 2 : (opc == 8'h0B) ? 1 : 0;
        for (int d = 0; d < nd; d++) begin
            xfer(8'($urandom), rx, all, any, held); quiet &= !any;
        end
        check(quiet, "R2 command phase quiet", 32'(!quiet), 0);
        for (int k = 0; k < len; k++) begin
            xfer(8'($urandom), rx, all, any, held);
            check(all && rx == exp_byte(binm, a, k), req, {23'd0, all, rx}, {24'd1, exp_byte(binm, a, k)});
            check(held, "R10 hold across rise", 32'(held), 1);
        end
        end_sel(1'b0);
    endtask

    function automatic logic [23:0] ext_addr(input int p, input int o, input logic [11:0] hi);
        return {hi, 2'(p), 10'(o)};
    endfunction

    function automatic logic [23:0] bin_addr(input int p, input int o, input logic [12:0] hi);
        return {hi, 2'(p), 9'(o)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx;
        bit all, any, held, rej_quiet;
        void'($urandom(32'd20240611));

        repeat (5) @(negedge clk);
        check(oe == 1'b0, "R1 in reset", oe, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(oe == 1'b0, "R1 after reset", oe, 0);

        // directed reads
        do_read(8'h03, ext_addr(1, 0, 12'h000), 1'b0, 6, 1'b0, "R2 slow read");
        do_read(8'h0B, ext_addr(0, 524, 12'hABC), 1'b0, 8, 1'b0, "R3 R5 page cross 528");
        do_read(8'h1B, ext_addr(3, 525, 12'h5A5), 1'b0, 6, 1'b0, "R4 R7 array wrap 528");
        do_read(8'h03, bin_addr(2, 508, 13'h1F0F), 1'b1, 8, 1'b0, "R6 page cross 512");
        do_read(8'h1B, bin_addr(3, 510, 13'h0000), 1'b1, 5, 1'b0, "R7 array wrap 512");
        do_read(8'h0B, ext_addr(2, 526, 12'h000), 1'b0, 4, 1'b1, "R11 mode 3");
        do_read(8'h03, bin_addr(3, 511, 13'h0001), 1'b1, 3, 1'b1, "R11 R7 mode 3 wrap");

        // unknown opcode
        bin_pages = 1'b0;
        begin_sel(1'b0);
        rej_quiet = 1'b1;
        xfer(8'h52, rx, all, any, held); rej_quiet &= !any;
        for (int k = 0; k < 5; k++) begin
            xfer(8'($urandom), rx, all, any, held); rej_quiet &= !any;
        end
        check(rej_quiet, "R9 unknown opcode silent", 32'(!rej_quiet), 0);
        end_sel(1'b0);
        do_read(8'h03, ext_addr(0, 3, 12'h000), 1'b0, 2, 1'b0, "R9 recovery");

        // release in the middle of a data byte
        begin_sel(1'b0);
        xfer(8'h03, rx, all, any, held);
        for (int k = 2; k >= 0; k--) xfer(8'h00, rx, all, any, held);
        for (int b = 0; b < 3; b++) begin
            sck = 1'b0; repeat (H) @(negedge clk);
            sck = 1'b1; repeat (H) @(negedge clk);
        end
        check(oe == 1'b1, "R8 streaming before release", oe, 1);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check(oe == 1'b0, "R8 mid-byte release", oe, 0);
        sck = 1'b0;
        repeat (H) @(negedge clk);
        do_read(8'h0B, ext_addr(1, 100, 12'h000), 1'b0, 3, 1'b0, "R8 fresh start");

        // constrained random reads biased to page ends
        for (int t = 0; t < 24; t++) begin
            logic [7:0]  opc;
            logic [23:0] a;
            bit binm, idle;
            int p, o, lim, len;
            case ($urandom % 3)
                0: opc = 8'h03;
                1: opc = 8'h0B;
                default: opc = 8'h1B;
            endcase
            binm = 1'($urandom);
            idle = 1'($urandom);
            p    = int'($urandom % PAGES);
            lim  = binm ? BIN : EXT;
            o    = ($urandom % 2 == 0) ? lim - 1 - int'($urandom % 4) : int'($urandom % lim);
            len  = 1 + int'($urandom % 10);
            a    = binm ? bin_addr(p, o, 13'($urandom)) : ext_addr(p, o, 12'($urandom));
            do_read(opc, a, binm, len, idle, binm ? "R6 random read" : "R5 random read");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule